// File: doc/BRIEF.md
# Flow-Through Synchronous Burst SRAM With Late-Write Pipeline

This block is a synthesizable behavioural model of a small synchronous SRAM. Reads are flow-through: the address is registered on a rising edge, and the array word drives `dout` in the clock period that follows. Writes are late-data: the command and address are registered on one edge, and the data and byte selects are taken on the next enabled edge. Because of this, a read can follow a write, or a write a read, on every clock with no idle cycle. The model turns off its own output drive while a write data phase is on the bus.

A two-bit burst counter sits below the registered address. The `adv` input continues the previous operation at the next burst address, in linear or interleaved order as chosen by `burst_ilv`. When `cke` is low, the clock edge is ignored and the whole pipeline holds.

The control path is a three-state machine held in `op_q`:

- IDLE: no access.
- READ: a read beat is on the bus.
- WRITE: the bus carries the data of a write beat.

The transitions, taken on an edge with `cke` high, are:

- *select-read*: any state goes to READ when all enables are active, `adv` is low and `wr_en` is low. This loads the address and clears the counter.
- *select-write*: any state goes to WRITE on the same condition with `wr_en` high.
- *deselect*: any state goes to IDLE when `adv` is low and any enable is inactive.
- *advance*: READ or WRITE stays in the same state and the counter steps by one. IDLE stays IDLE under `adv`.
- *stall*: with `cke` low, every state holds.

Top module: `fts_sram`

## Requirements
- R1: While `rst_n` is low and after its release with no command yet, `dq_oe` is 0 and the state is IDLE.
- R2: On an edge with `cke` low, the block ignores every input and holds all state, so `dq_oe` and `dout` keep their values from the previous cycle.
- R3: An access starts only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 on an enabled edge with `adv`=0. Any other combination is a deselect, and `dq_oe` is 0 in the following cycle.
- R4: A read registered on an edge drives `dout` with the addressed word in the next clock period, with `dq_oe`=1 when `oe_n` is low. There is no further register stage.
- R5: Write data `din` and `byte_en` are sampled on the next enabled edge after the write command. Stalled edges in between sample nothing.
- R6: Byte lane i is `din[8i+7:8i]`. It is written only when `byte_en[i]`=1; the other lanes of the word keep their old contents.
- R7: During the cycle after a write command or write burst beat, `dq_oe` is 0 whatever `oe_n` is.
- R8: `oe_n`=1 forces `dq_oe` to 0 without waiting for a clock edge.
- R9: Reads and writes may alternate on every enabled edge with no idle cycle. A read issued on the edge that takes a write's data to the same address returns the new data.
- R10: With `adv`=1, the previous operation type continues and the 2-bit counter steps by one, wrapping modulo 4. After a deselect, `adv` leaves the block deselected.
- R11: With `burst_ilv`=0 latched at the command, the low two address bits of beat n are (start + n) mod 4.
- R12: With `burst_ilv`=1 latched at the command, the low two address bits of beat n are start XOR n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of control state |
| cke | input | 1 | Clock enable; low stalls the block |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| wr_en | input | 1 | 1 selects write, 0 selects read on a new command |
| byte_en | input | LANES | Byte write selects, taken in the write data phase |
| addr | input | AW | Word address |
| adv | input | 1 | Burst advance: continue the previous operation |
| burst_ilv | input | 1 | 1 selects interleaved order, 0 selects linear order |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LW | Write data |
| dout | output | LANES*LW | Read data, zero when not driving |
| dq_oe | output | 1 | Output drive enable of the data bus |

## Verification
The hardest situations to reach are two edges that do two jobs at once. In the first, one enabled edge commits a write's data and also registers a read of the same word. In the second, a stall lands inside a write data phase, so junk on `din` must be ignored and the real data taken one edge later. The stimulus uses back-to-back write/read pairs on the same addresses for the first. For the second, it inserts `cke`-low cycles between a write command and its data, and between a read and the following cycle.

Every cycle, the driver computes the expected drive and data from its own array model and burst counter and pushes them to a queue. A monitor compares them half a cycle later. This covers linear and interleaved bursts that start in the middle of a group of four, so the wrap is exercised.

// File: rtl/fts_pkg.sv
package fts_pkg;
    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/fts_burst_seq.sv
module fts_burst_seq #(
    parameter int unsigned CW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] cnt,
    input  logic          ilv,
    output logic [CW-1:0] lo
);
    logic [CW-1:0] lin_lo;
    logic [CW-1:0] ilv_lo;

    always_comb begin
        lin_lo = start + cnt;
        ilv_lo = start ^ cnt;
        lo     = ilv ? ilv_lo : lin_lo;
    end

    // R11
    first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |-> (lo == start));
endmodule

// File: rtl/fts_cmd_fsm.sv
module fts_cmd_fsm
    import fts_pkg::*;
#(
    parameter int unsigned AW = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cke,
    input  logic                sel,
    input  logic                wr,
    input  logic                adv,
    input  logic                ilv_in,
    input  logic [AW-1:0]       addr,
    output op_e                 op_q,
    output logic [AW-1:0]       base_q,
    output logic [BURST_W-1:0]  cnt_q,
    output logic                ilv_q
);
    op_e                op_d;
    logic [AW-1:0]      base_d;
    logic [BURST_W-1:0] cnt_d;
    logic               ilv_d;

    always_comb begin
        op_d   = op_q;
        base_d = base_q;
        cnt_d  = cnt_q;
        ilv_d  = ilv_q;
        if (cke) begin
            if (adv) begin
                unique case (op_q)
                    OP_IDLE:            cnt_d = cnt_q;
                    OP_READ, OP_WRITE:  cnt_d = cnt_q + 1'b1;
                    default:            cnt_d = cnt_q;
                endcase
            end else if (sel) begin
                op_d   = wr ? OP_WRITE : OP_READ;
                base_d = addr;
                cnt_d  = '0;
                ilv_d  = ilv_in;
            end else begin
                op_d = OP_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
            ilv_q  <= 1'b0;
        end else begin
            op_q   <= op_d;
            base_q <= base_d;
            cnt_q  <= cnt_d;
            ilv_q  <= ilv_d;
        end
    end

    // R2
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(op_q) && $stable(base_q) && $stable(cnt_q) && $stable(ilv_q)));

    // R10
    burst_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && adv && op_q != OP_IDLE) |=> (cnt_q == BURST_W'($past(cnt_q) + 1'b1)));

    // R10
    adv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && adv && op_q == OP_IDLE) |=> (op_q == OP_IDLE));
endmodule

// File: rtl/fts_array.sv
module fts_array #(
    parameter int unsigned AW    = 6,
    parameter int unsigned LANES = 4,
    parameter int unsigned LW    = 8
) (
    input  logic                  clk,
    input  logic                  we,
    input  logic [LANES-1:0]      be,
    input  logic [AW-1:0]         waddr,
    input  logic [LANES*LW-1:0]   wdata,
    input  logic [AW-1:0]         raddr,
    output logic [LANES*LW-1:0]   rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [LANES*LW-1:0] mem [DEPTH];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && be[g]) begin
                mem[waddr][g*LW +: LW] <= wdata[g*LW +: LW];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/fts_sram.sv
module fts_sram
    import fts_pkg::*;
#(
    parameter int unsigned AW    = 6,
    parameter int unsigned LANES = 4,
    parameter int unsigned LW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cke,
    input  logic                 cs1_n,
    input  logic                 cs2,
    input  logic                 cs3_n,
    input  logic                 wr_en,
    input  logic [LANES-1:0]     byte_en,
    input  logic [AW-1:0]        addr,
    input  logic                 adv,
    input  logic                 burst_ilv,
    input  logic                 oe_n,
    input  logic [LANES*LW-1:0]  din,
    output logic [LANES*LW-1:0]  dout,
    output logic                 dq_oe
);
    localparam int unsigned DW = LANES * LW;

    logic               sel;
    op_e                op_q;
    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] cnt_q;
    logic               ilv_q;
    logic [BURST_W-1:0] lo;
    logic [AW-1:0]      eff_addr;
    logic               commit;
    logic [DW-1:0]      rdata;

    assign sel = !cs1_n && cs2 && !cs3_n;

    fts_cmd_fsm #(.AW(AW)) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .cke    (cke),
        .sel    (sel),
        .wr     (wr_en),
        .adv    (adv),
        .ilv_in (burst_ilv),
        .addr   (addr),
        .op_q   (op_q),
        .base_q (base_q),
        .cnt_q  (cnt_q),
        .ilv_q  (ilv_q)
    );

    fts_burst_seq #(.CW(BURST_W)) seq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .start (base_q[BURST_W-1:0]),
        .cnt   (cnt_q),
        .ilv   (ilv_q),
        .lo    (lo)
    );

    assign eff_addr = {base_q[AW-1:BURST_W], lo};
    assign commit   = cke && (op_q == OP_WRITE);

    fts_array #(.AW(AW), .LANES(LANES), .LW(LW)) array_i (
        .clk   (clk),
        .we    (commit),
        .be    (byte_en),
        .waddr (eff_addr),
        .wdata (din),
        .raddr (eff_addr),
        .rdata (rdata)
    );

    always_comb begin
        dq_oe = 1'b0;
        dout  = '0;
        unique case (op_q)
            OP_IDLE:  dq_oe = 1'b0;
            OP_WRITE: dq_oe = 1'b0;
            OP_READ:  dq_oe = !oe_n;
            default:  dq_oe = 1'b0;
        endcase
        if (dq_oe) begin
            dout = rdata;
        end
    end

    // R3
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !sel && !adv) |=> !dq_oe);

    // R7
    wr_phase_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && sel && wr_en && !adv) |=> !dq_oe);

    // R4
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && sel && !wr_en && !adv) |=> (dq_oe == !oe_n));
endmodule

// File: tb/fts_sram_tb_top.sv
module fts_sram_tb_top;
    localparam int AW = 6;
    localparam int LANES = 4;
    localparam int LW = 8;
    localparam int DW = LANES * LW;

    typedef struct {
        bit           oe;
        logic [DW-1:0] d;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic wr_en = 1'b0, adv = 1'b0, burst_ilv = 1'b0, oe_n = 1'b0;
    logic [LANES-1:0] byte_en = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dq_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    exp_t q[$];
    logic [DW-1:0] model [1<<AW];
    int b_op = 0;
    int b_base = 0;
    int b_cnt = 0;
    bit b_ilv = 0;
    exp_t last_e;

    always #4 clk = ~clk;

    fts_sram #(.AW(AW), .LANES(LANES), .LW(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n),
        .wr_en(wr_en), .byte_en(byte_en), .addr(addr), .adv(adv), .burst_ilv(burst_ilv),
        .oe_n(oe_n), .din(din), .dout(dout), .dq_oe(dq_oe)
    );

    function automatic int eff();
        int lo;
        lo = b_ilv ? ((b_base & 3) ^ b_cnt) : (((b_base & 3) + b_cnt) & 3);
        return (b_base & ~3) | lo;
    endfunction

    task automatic check(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check(dq_oe == e.oe, {e.tag, " drive"}, {31'b0, dq_oe}, {31'b0, e.oe});
            if (e.oe && dq_oe) check(dout == e.d, {e.tag, " data"}, dout, e.d);
        end
    end

    // op: 0 deselect, 1 read, 2 write; csm picks which enable is inactive on deselect
    task automatic go(bit c, int op, int csm, bit ad, bit il, int a, bit oen,
                      logic [DW-1:0] wd, logic [LANES-1:0] be, string tag);
        exp_t e;
        cke = c; adv = ad; burst_ilv = il; addr = AW'(a); oe_n = oen; din = wd; byte_en = be;
        wr_en = (op == 2);
        cs1_n = 1'b0; cs2 = 1'b1; cs3_n = 1'b0;
        if (op == 0) begin
            if (csm == 1) cs2 = 1'b0;
            else if (csm == 2) cs3_n = 1'b1;
            else cs1_n = 1'b1;
        end
        @(posedge clk);
        if (c) begin
            if (b_op == 2) begin
                int w;
                w = eff();
                for (int i = 0; i < LANES; i++)
                    if (be[i]) model[w][i*LW +: LW] = wd[i*LW +: LW];
            end
            if (ad) begin
                if (b_op != 0) b_cnt = (b_cnt + 1) & 3;
            end else if (op != 0) begin
                b_op = op; b_base = a; b_cnt = 0; b_ilv = il;
            end else begin
                b_op = 0;
            end
            e.oe = (b_op == 1) && !oen;
            e.d = (b_op == 1) ? model[eff()] : '0;
        end else begin
            e = last_e;
        end
        e.tag = tag;
        last_e = e;
        q.push_back(e);
        @(negedge clk);
        #1;
    endtask

    function automatic logic [DW-1:0] pat(int i);
        return 32'h1000_0000 + 32'(i) * 32'h0103_0507;
    endfunction

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        last_e.oe = 0; last_e.d = '0; last_e.tag = "";
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(dq_oe == 1'b0, "R1 in reset", {31'b0, dq_oe}, '0);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(dq_oe == 1'b0, "R1 after release", {31'b0, dq_oe}, '0);
        #1;

        // R10 R11: fill the array with linear write bursts of four
        n = 0;
        for (int k = 0; k < 16; k++) begin
            for (int b = 0; b < 4; b++) begin
                go(1, 2, 0, b != 0, 0, 4*k, 0, pat(n), (n == 0) ? 4'h0 : 4'hf, "R7 fill");
                n++;
            end
        end
        go(1, 1, 0, 0, 0, 0, 0, pat(n), 4'hf, "R9 last fill data");

        // R11: linear read burst from the middle of a group
        go(1, 1, 0, 0, 0, 6, 0, '0, '0, "R11 beat0");
        for (int b = 1; b < 4; b++) go(1, 1, 0, 1, 0, 0, 0, '0, '0, "R11 wrap");

        // R12: interleaved read burst
        go(1, 1, 0, 0, 1, 9, 0, '0, '0, "R12 beat0");
        for (int b = 1; b < 4; b++) go(1, 1, 0, 1, 0, 0, 0, '0, '0, "R12 order");

        // R12: interleaved write burst, then interleaved read back
        go(1, 2, 0, 0, 1, 43, 0, '0, '0, "R12 wr cmd");
        for (int b = 1; b < 4; b++) go(1, 2, 0, 1, 0, 0, 0, pat(200 + b), 4'hf, "R12 wr beat");
        go(1, 1, 0, 0, 1, 42, 0, pat(204), 4'hf, "R12 rd beat0");
        for (int b = 1; b < 4; b++) go(1, 1, 0, 1, 0, 0, 0, '0, '0, "R12 rd burst");

        // R9: alternating writes and reads on the same address, no idle
        for (int i = 0; i < 4; i++) begin
            go(1, 2, 0, 0, 0, 20 + i, 0, '0, '0, "R9 wr");
            go(1, 1, 0, 0, 0, 20 + i, 0, pat(300 + i), 4'hf, "R9 rd after wr");
        end

        // R6: partial byte write
        go(1, 2, 0, 0, 0, 30, 0, '0, '0, "R6 wr");
        go(1, 1, 0, 0, 0, 30, 0, 32'hDEAD_BEEF, 4'b0101, "R6 lanes");
        go(1, 2, 0, 0, 0, 31, 0, '0, '0, "R6 wr");
        go(1, 1, 0, 0, 0, 31, 0, 32'h1234_5678, 4'b1000, "R6 top lane");

        // R2: stall during a read keeps the output
        go(1, 1, 0, 0, 0, 3, 0, '0, '0, "R2 rd");
        go(0, 2, 0, 0, 0, 50, 0, '0, '0, "R2 stalled hold");
        go(0, 0, 0, 0, 0, 51, 0, '0, '0, "R2 stalled hold");

        // R5: stall inside a write data phase
        go(1, 2, 0, 0, 0, 5, 0, '0, '0, "R5 wr cmd");
        go(0, 1, 0, 0, 0, 9, 0, 32'hBAD0_BAD0, 4'hf, "R5 stall no sample");
        go(1, 1, 0, 0, 0, 5, 0, 32'hC0DE_0005, 4'hf, "R5 data taken late");

        // R3: each enable on its own deselects; R10 advance stays deselected
        go(1, 0, 0, 0, 0, 5, 0, '0, '0, "R3 cs1_n off");
        go(1, 1, 0, 0, 0, 5, 0, '0, '0, "R3 reselect");
        go(1, 0, 1, 0, 0, 5, 0, '0, '0, "R3 cs2 off");
        go(1, 1, 0, 0, 0, 6, 0, '0, '0, "R3 reselect");
        go(1, 0, 2, 0, 0, 6, 0, '0, '0, "R3 cs3_n off");
        go(1, 0, 2, 1, 0, 6, 0, '0, '0, "R10 adv after deselect");

        // R8 and R7: output enable gating
        go(1, 1, 0, 0, 0, 7, 1, '0, '0, "R8 oe_n high");
        go(1, 1, 0, 0, 0, 7, 0, '0, '0, "R8 oe_n low");
        go(1, 2, 0, 0, 0, 8, 0, '0, '0, "R7 wr phase oe_n low");
        go(1, 1, 0, 0, 0, 8, 0, 32'h0808_0808, 4'hf, "R7 rd back");
        go(1, 0, 0, 0, 0, 0, 0, '0, '0, "R3 idle");

        @(negedge clk);
        #1 oe_n = 1'b1;
        go(1, 1, 0, 0, 0, 8, 0, '0, '0, "R8 rd");
        #1 oe_n = 1'b1;
        #1 check(dq_oe == 1'b0, "R8 async", {31'b0, dq_oe}, '0);
        #1 oe_n = 1'b0;
        #1 check(dq_oe == 1'b1, "R8 async release", {31'b0, dq_oe}, 32'd1);
        go(1, 0, 0, 0, 0, 0, 0, '0, '0, "R3 end");

        repeat (2) @(negedge clk);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule